// File: doc/BRIEF.md
# External Data Space Access Router

This block sits beside an 8051-class core and steers each external-data (MOVX) read or write to one of three places: a 768-byte on-chip expanded RAM, an on-chip data flash that can only be read, or the off-chip memory bus. It holds the registers that shape the access: the two bytes of the 16-bit data pointer, a page register, and a configuration register with two enable bits. The core writes these registers with ordinary SFR writes.

A request comes in one of two forms. The pointer form uses the whole data pointer as the 16-bit address. The indexed form takes the high address byte from the page register and the low byte from the index register (R0 or R1) that the core presents with the request. Two enable bits decide where the address lands. Addresses up to 02FFh may go to internal RAM. Everything else goes to the flash or to the off-chip bus. During the request cycle the router drives one select per target, a common address and per-target strobes, all from combinational logic. A write aimed at the read-only flash is dropped and flagged.

Top module: `xdata_router`

## Requirements
- R1: After reset, the data pointer low byte (82h), the data pointer high byte (83h), the page register (parameter, default 92h) and the configuration register (BFh) all read back 00h, and no select is asserted.
- R2: An SFR write to 82h, 83h or the page address stores the full byte, and that byte reads back on the next cycle. At BFh only bit 0 (RAM enable) and bit 1 (flash enable) are stored, and the other bits read 0. A write to any other SFR address changes none of the four registers.
- R3: In the pointer form (req_indirect=0), the output address equals {data pointer high, data pointer low}, and req_index has no effect.
- R4: In the indexed form (req_indirect=1), the output address equals {page register, req_index}.
- R5: With both enables at 0, every address selects the off-chip bus.
- R6: With only the RAM enable set, addresses 0000h–02FFh select internal RAM and higher addresses select the off-chip bus.
- R7: With only the flash enable set, every address selects the data flash.
- R8: With both enables set, addresses 0000h–02FFh select internal RAM and higher addresses select the data flash.
- R9: While req_valid is high, exactly one of sel_ram, sel_flash and sel_ext is high. While req_valid is low, all three are low.
- R10: A read asserts only the read strobe of the selected target. A write to RAM or to the off-chip bus asserts only that target's write strobe.
- R11: A write that decodes to the data flash asserts no strobe and raises wr_err for that cycle only. wr_err is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr_en | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for write and read-back |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Read-back of the addressed router SFR (00h if not one of them) |
| req_valid | input | 1 | MOVX request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = indexed form, 0 = pointer form |
| req_index | input | 8 | Value of the selected R0/R1 |
| sel_ram | output | 1 | Internal RAM selected |
| sel_flash | output | 1 | Data flash selected |
| sel_ext | output | 1 | Off-chip bus selected |
| xaddr | output | 16 | Formed MOVX address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| flash_re | output | 1 | Flash read strobe |
| ext_we | output | 1 | Off-chip write strobe |
| ext_re | output | 1 | Off-chip read strobe |
| wr_err | output | 1 | Write to read-only flash attempted |

## Verification
The decode is swept through all four enable combinations, both address forms, every high byte 00h–FFh and the low bytes 00h, 7Fh and FFh, with both reads and writes. This sweep covers the 02FFh/0300h boundary from both sides, and with the enable combinations it tells the RAM-window modes apart from the pass-through modes. In the pointer form, req_index is driven to the inverse of the low byte, so an address taken from the wrong source shows up at once. SFR tests write full bytes, write all ones to the configuration register, and write to an unrelated address. These tests separate stored bits from masked ones and catch stray decodes.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
  typedef enum logic [1:0] {
    TGT_EXT   = 2'd0,
    TGT_RAM   = 2'd1,
    TGT_FLASH = 2'd2
  } tgt_e;

  typedef struct packed {
    logic [7:0] ptr_lo;
    logic [7:0] ptr_hi;
    logic [7:0] page;
    logic       ram_en;
    logic       flash_en;
  } xdr_cfg_t;
endpackage

// File: rtl/xdr_rst_sync.sv
module xdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/xdr_sfr_regs.sv
module xdr_sfr_regs
  import xdr_pkg::*;
#(
  parameter logic [7:0] PTR_LO_ADDR  = 8'h82,
  parameter logic [7:0] PTR_HI_ADDR  = 8'h83,
  parameter logic [7:0] PAGE_ADDR    = 8'h92,
  parameter logic [7:0] CFG_ADDR     = 8'hBF,
  parameter int         RAM_EN_BIT   = 0,
  parameter int         FLASH_EN_BIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output xdr_cfg_t   cfg,
  output logic [7:0] rdata
);
  localparam int NBYTE = 3;

  function automatic logic [7:0] byte_addr(input int idx);
    case (idx)
      0:       return PTR_LO_ADDR;
      1:       return PTR_HI_ADDR;
      default: return PAGE_ADDR;
    endcase
  endfunction

  logic [7:0] byte_q [NBYTE];
  logic       ram_en_q, flash_en_q;
  logic       ram_en_d, flash_en_d;
  logic       cfg_ce;

  for (genvar gi = 0; gi < NBYTE; gi++) begin : g_byte
    logic       ce;
    logic [7:0] d;
    always_comb begin
      ce = wr_en && (addr == byte_addr(gi));
      d  = ce ? wdata : byte_q[gi];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[gi] <= 8'h00;
      else        byte_q[gi] <= d;
    end
  end

  always_comb begin
    cfg_ce     = wr_en && (addr == CFG_ADDR);
    ram_en_d   = cfg_ce ? wdata[RAM_EN_BIT]   : ram_en_q;
    flash_en_d = cfg_ce ? wdata[FLASH_EN_BIT] : flash_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en_q   <= 1'b0;
      flash_en_q <= 1'b0;
    end else begin
      ram_en_q   <= ram_en_d;
      flash_en_q <= flash_en_d;
    end
  end

  always_comb begin
    cfg.ptr_lo   = byte_q[0];
    cfg.ptr_hi   = byte_q[1];
    cfg.page     = byte_q[2];
    cfg.ram_en   = ram_en_q;
    cfg.flash_en = flash_en_q;
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == PTR_LO_ADDR)      rdata = byte_q[0];
    else if (addr == PTR_HI_ADDR) rdata = byte_q[1];
    else if (addr == PAGE_ADDR)   rdata = byte_q[2];
    else if (addr == CFG_ADDR) begin
      rdata[RAM_EN_BIT]   = ram_en_q;
      rdata[FLASH_EN_BIT] = flash_en_q;
    end
  end
endmodule

// File: rtl/xdr_addr_gen.sv
module xdr_addr_gen
  import xdr_pkg::*;
(
  input  xdr_cfg_t    cfg,
  input  logic        indirect,
  input  logic [7:0]  index,
  output logic [15:0] addr
);
  always_comb begin
    if (indirect) addr = {cfg.page, index};
    else          addr = {cfg.ptr_hi, cfg.ptr_lo};
  end
endmodule

// File: rtl/xdr_decode.sv
module xdr_decode
  import xdr_pkg::*;
#(
  parameter logic [15:0] RAM_TOP = 16'h02FF
) (
  input  logic        valid,
  input  logic        write,
  input  logic [15:0] addr,
  input  logic        ram_en,
  input  logic        flash_en,
  output logic        sel_ram,
  output logic        sel_flash,
  output logic        sel_ext,
  output logic        ram_we,
  output logic        ram_re,
  output logic        flash_re,
  output logic        ext_we,
  output logic        ext_re,
  output logic        wr_err
);
  tgt_e tgt;
  logic in_window;

  always_comb begin
    in_window = (addr <= RAM_TOP);
    if (ram_en && in_window) tgt = TGT_RAM;
    else if (flash_en)       tgt = TGT_FLASH;
    else                     tgt = TGT_EXT;
  end

  always_comb begin
    sel_ram   = valid && (tgt == TGT_RAM);
    sel_flash = valid && (tgt == TGT_FLASH);
    sel_ext   = valid && (tgt == TGT_EXT);
    ram_we    = sel_ram   &&  write;
    ram_re    = sel_ram   && !write;
    flash_re  = sel_flash && !write;
    wr_err    = sel_flash &&  write;
    ext_we    = sel_ext   &&  write;
    ext_re    = sel_ext   && !write;
  end
endmodule

// File: rtl/xdata_router.sv
module xdata_router
  import xdr_pkg::*;
#(
  parameter logic [7:0]  PAGE_ADDR = 8'h92,
  parameter logic [7:0]  CFG_ADDR  = 8'hBF,
  parameter logic [15:0] RAM_TOP   = 16'h02FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_wr_en,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_indirect,
  input  logic [7:0]  req_index,
  output logic        sel_ram,
  output logic        sel_flash,
  output logic        sel_ext,
  output logic [15:0] xaddr,
  output logic        ram_we,
  output logic        ram_re,
  output logic        flash_re,
  output logic        ext_we,
  output logic        ext_re,
  output logic        wr_err
);
  logic     rst_n_int;
  xdr_cfg_t cfg;

  xdr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  xdr_sfr_regs #(
    .PTR_LO_ADDR  (8'h82),
    .PTR_HI_ADDR  (8'h83),
    .PAGE_ADDR    (PAGE_ADDR),
    .CFG_ADDR     (CFG_ADDR),
    .RAM_EN_BIT   (0),
    .FLASH_EN_BIT (1)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr_en (sfr_wr_en),
    .addr  (sfr_addr),
    .wdata (sfr_wdata),
    .cfg   (cfg),
    .rdata (sfr_rdata)
  );

  xdr_addr_gen u_agen (
    .cfg      (cfg),
    .indirect (req_indirect),
    .index    (req_index),
    .addr     (xaddr)
  );

  xdr_decode #(.RAM_TOP(RAM_TOP)) u_dec (
    .valid     (req_valid),
    .write     (req_write),
    .addr      (xaddr),
    .ram_en    (cfg.ram_en),
    .flash_en  (cfg.flash_en),
    .sel_ram   (sel_ram),
    .sel_flash (sel_flash),
    .sel_ext   (sel_ext),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .flash_re  (flash_re),
    .ext_we    (ext_we),
    .ext_re    (ext_re),
    .wr_err    (wr_err)
  );
endmodule

// File: rtl/xdr_checker.sv
module xdr_checker #(
  parameter logic [15:0] RAM_TOP = 16'h02FF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        sel_ram,
  input logic        sel_flash,
  input logic        sel_ext,
  input logic [15:0] xaddr,
  input logic        ram_we,
  input logic        ram_re,
  input logic        flash_re,
  input logic        ext_we,
  input logic        ext_re,
  input logic        wr_err,
  input logic        cfg_ram_en,
  input logic        cfg_flash_en
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones({sel_ram, sel_flash, sel_ext}) == 1)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({sel_ram, sel_flash, sel_ext, wr_err} == 4'b0)); // R9
  AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram |-> (cfg_ram_en && xaddr <= RAM_TOP)); // R6
  AST_FLASH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_flash |-> cfg_flash_en); // R7
  AST_EXT_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> !cfg_flash_en); // R5
  AST_FLASH_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !(ram_we || ext_we || flash_re || ram_re || ext_re)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, ram_re, flash_re, ext_we, ext_re, wr_err})); // R10
  AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> !(ram_we || ext_we || wr_err)); // R10
endmodule

bind xdata_router xdr_checker #(.RAM_TOP(RAM_TOP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_int),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .sel_ram      (sel_ram),
  .sel_flash    (sel_flash),
  .sel_ext      (sel_ext),
  .xaddr        (xaddr),
  .ram_we       (ram_we),
  .ram_re       (ram_re),
  .flash_re     (flash_re),
  .ext_we       (ext_we),
  .ext_re       (ext_re),
  .wr_err       (wr_err),
  .cfg_ram_en   (cfg.ram_en),
  .cfg_flash_en (cfg.flash_en)
);

// File: tb/sim_xdata_router.sv
module sim_xdata_router;
  logic        clk;
  logic        rst_n;
  logic        sfr_wr_en;
  logic [7:0]  sfr_addr;
  logic [7:0]  sfr_wdata;
  logic [7:0]  sfr_rdata;
  logic        req_valid, req_write, req_indirect;
  logic [7:0]  req_index;
  logic        sel_ram, sel_flash, sel_ext;
  logic [15:0] xaddr;
  logic        ram_we, ram_re, flash_re, ext_we, ext_re, wr_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [7:0] A_LO = 8'h82, A_HI = 8'h83, A_PG = 8'h92, A_CFG = 8'hBF;

  xdata_router u0 (
    .clk(clk), .rst_n(rst_n), .sfr_wr_en(sfr_wr_en), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_indirect(req_indirect), .req_index(req_index),
    .sel_ram(sel_ram), .sel_flash(sel_flash), .sel_ext(sel_ext), .xaddr(xaddr),
    .ram_we(ram_we), .ram_re(ram_re), .flash_re(flash_re), .ext_we(ext_we),
    .ext_re(ext_re), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr_en = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr_en = 1'b0;
  endtask

  task automatic sfr_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a;
    #1;
    chk(req, {24'h0, sfr_rdata}, {24'h0, exp});
  endtask

  // one request, checked a quarter period after the driving falling edge
  task automatic do_req(input bit ind, input bit wr, input logic [7:0] idx,
                        input logic [15:0] exp_a, input logic [1:0] mode);
    logic [2:0] es;
    logic [5:0] estb;
    string mtag;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_indirect = ind; req_index = idx;
    #5;
    if (mode[0] && exp_a <= 16'h02FF) es = 3'b100;
    else if (mode[1])                 es = 3'b010;
    else                              es = 3'b001;
    // {ram_we, ram_re, flash_re, ext_we, ext_re, wr_err}
    estb = {es[2] & wr, es[2] & ~wr, es[1] & ~wr, es[0] & wr, es[0] & ~wr, es[1] & wr};
    case (mode)
      2'd0: mtag = "R5";
      2'd1: mtag = "R6";
      2'd2: mtag = "R7";
      default: mtag = "R8";
    endcase
    chk(ind ? "R4" : "R3", {16'h0, xaddr}, {16'h0, exp_a});
    chk(mtag, {29'h0, sel_ram, sel_flash, sel_ext}, {29'h0, es});
    chk((es[1] & wr) ? "R11" : "R10",
        {26'h0, ram_we, ram_re, flash_re, ext_we, ext_re, wr_err}, {26'h0, estb});
    @(negedge clk);
    req_valid = 1'b0;
    #5;
    chk("R9", {28'h0, sel_ram, sel_flash, sel_ext, wr_err}, 32'h0);
  endtask

  initial begin
    sfr_wr_en = 0; sfr_addr = 0; sfr_wdata = 0;
    req_valid = 0; req_write = 0; req_indirect = 0; req_index = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    sfr_rd("R1", A_LO, 8'h00);
    sfr_rd("R1", A_HI, 8'h00);
    sfr_rd("R1", A_PG, 8'h00);
    sfr_rd("R1", A_CFG, 8'h00);
    chk("R1", {29'h0, sel_ram, sel_flash, sel_ext}, 32'h0);

    // R2 register writes, masking and stray addresses
    sfr_wr(A_LO, 8'hA5);  sfr_rd("R2", A_LO, 8'hA5);
    sfr_wr(A_HI, 8'h3C);  sfr_rd("R2", A_HI, 8'h3C);
    sfr_wr(A_PG, 8'hE7);  sfr_rd("R2", A_PG, 8'hE7);
    sfr_wr(A_CFG, 8'hFF); sfr_rd("R2", A_CFG, 8'h03);
    sfr_wr(8'h90, 8'h5A);
    sfr_rd("R2", A_LO, 8'hA5);
    sfr_rd("R2", A_HI, 8'h3C);
    sfr_rd("R2", A_PG, 8'hE7);
    sfr_rd("R2", A_CFG, 8'h03);
    sfr_wr(A_CFG, 8'hFE); sfr_rd("R2", A_CFG, 8'h02);

    // main sweep: modes x forms x pages x low bytes x direction
    for (int m = 0; m < 4; m++) begin
      sfr_wr(A_CFG, {6'b0, m[1:0]});
      for (int f = 0; f < 2; f++) begin
        for (int pg = 0; pg < 256; pg++) begin
          if (f == 0) sfr_wr(A_HI, pg[7:0]);
          else        sfr_wr(A_PG, pg[7:0]);
          for (int li = 0; li < 3; li++) begin
            logic [7:0] lo;
            lo = (li == 0) ? 8'h00 : (li == 1) ? 8'h7F : 8'hFF;
            if (f == 0) sfr_wr(A_LO, lo);
            for (int w = 0; w < 2; w++) begin
              if (f == 0) do_req(1'b0, w[0], ~lo, {pg[7:0], lo}, m[1:0]);
              else        do_req(1'b1, w[0], lo,  {pg[7:0], lo}, m[1:0]);
            end
          end
        end
      end
    end

    // R11 error pulse ends after a single cycle even with request held idle-to-valid
    sfr_wr(A_CFG, 8'h02);
    sfr_wr(A_PG, 8'h40);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_indirect = 1'b1; req_index = 8'h10;
    #5;
    chk("R11", {31'h0, wr_err}, 32'h1);
    @(negedge clk);
    req_write = 1'b0;
    #5;
    chk("R11", {30'h0, wr_err, flash_re}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule